// File: doc/BRIEF.md
# Balanced Dual-Copy DRAM Command/Address Driver

This block is the registered output stage for a DRAM command/address bus that is driven twice, as two physical copies, from one incoming command stream. A command is presented on `cmd_*` and appears on both copies after one clock edge. The chip-select and RAS/CAS/WE values are the same on both copies. On copy 1, the bank and address bits are the bitwise inverse of copy 0. Because of this, the termination supply sinks about as much current as it sources. Some commands need a bit to carry its true value on both copies, and there the inversion is skipped. A configuration bit can also turn the balancing off entirely.

When no command is issued, the bus carries a balanced deselect. Both copies keep the bank and address of the last issued command. Pad tri-state buffers are outside the block, so each pin group gets an output-enable signal. The enables follow these rules:

- In deep sleep (S3), every output is driven low.
- In core reset, only CKE and ODT are driven, both low, and the clock keeps running.
- Separate float bits turn off individual pin groups.
- During CKE power-down, the command and chip-select pins float.

Top module: `ca_balance_drv`

## Requirements
- R1: While `rst_n` is low, both copies show chip selects all 1, RAS/CAS/WE 0, copy 0 bank and address all 0, and copy 1 bank and address all 1. `cke_o`, `odt_o`, `ck_run` and every `oe_*` are 0.
- R2: Each output changes on the clock edge that samples its inputs. A command is issued when `cmd_valid` is 1, at least one `cmd_cs_n` bit is 0 and {ras,cas,we} is not 111 (NOP). The {ras,cas,we} codes are: 000 mode register set, 010 precharge, 100 write, 101 read, 011 activate, 001 refresh. Both copies carry the same chip-select and RAS/CAS/WE values.
- R3: For an issued command that no exception covers, `c1_bank`/`c1_addr` equal the bitwise inverse of `c0_bank`/`c0_addr`. `c0_*` carry the command values unchanged.
- R4: In a cycle with no issued command, both copies show chip selects all 1 and RAS/CAS/WE all 0, and each copy keeps its previous bank and address.
- R5: For read, write and precharge, address bit 10 has the same value on both copies.
- R6: For mode register set, copy 1 bank and address equal copy 0.
- R7: With `cfg_seq_a0` = 1, address bit 0 is uninverted for read, write and precharge only. Other commands still invert it.
- R8: With `cfg_bal_off` = 1, both copies are identical for every command.
- R9: With `sleep_s3` = 1, every output value is driven low: all command/address bits, `cke_o`, `odt_o` and `ck_run` (0 means the clock is held low). All `oe_*` are 1. Commands are not taken, so the held address survives the sleep.
- R10: With `core_rst` = 1 (and no sleep), the outputs are set as follows:
  - `cke_o` and `odt_o` are 0, and `ck_run` is 1.
  - `oe_cke`, `oe_odt` and `oe_ck` are 1.
  - `oe_ca` and `oe_cs` are 0.
  - Commands are not taken.
- R11: In normal operation, `flt_ca`, `flt_cs`, `flt_odt`, `flt_cke` and `flt_ck` each clear only their own enable: `oe_ca`, `oe_cs`, `oe_odt`, `oe_cke` and `oe_ck` respectively.
- R12: The first edge that drives every CKE bit to 0 leaves `oe_ca`/`oe_cs` at 1. From the next edge on, while `cke_o` stays all 0, they are 0. They return to 1 on the same edge that drives any CKE bit to 1.
- R13: The enable rules apply in priority order: sleep, then core reset, then the float bits, then CKE power-down.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | DRAM command clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| core_rst | input | 1 | Core logic is in reset |
| sleep_s3 | input | 1 | Deep-sleep (S3) state |
| cfg_bal_off | input | 1 | Disable copy-1 inversion |
| cfg_seq_a0 | input | 1 | Keep address bit 0 uninverted on read/write/precharge |
| flt_ca | input | 1 | Float RAS/CAS/WE/bank/address |
| flt_cs | input | 1 | Float chip selects |
| flt_odt | input | 1 | Float ODT |
| flt_cke | input | 1 | Float CKE |
| flt_ck | input | 1 | Float clock |
| cmd_valid | input | 1 | Command present |
| cmd_cs_n | input | NCS | Command chip selects, active low |
| cmd_ras_n | input | 1 | Command RAS |
| cmd_cas_n | input | 1 | Command CAS |
| cmd_we_n | input | 1 | Command WE |
| cmd_bank | input | BW | Command bank |
| cmd_addr | input | AW | Command address |
| cke_req | input | NCKE | Requested CKE levels |
| odt_req | input | NODT | Requested ODT levels |
| c0_cs_n | output | NCS | Copy 0 chip selects |
| c0_ras_n | output | 1 | Copy 0 RAS |
| c0_cas_n | output | 1 | Copy 0 CAS |
| c0_we_n | output | 1 | Copy 0 WE |
| c0_bank | output | BW | Copy 0 bank |
| c0_addr | output | AW | Copy 0 address |
| c1_cs_n | output | NCS | Copy 1 chip selects |
| c1_ras_n | output | 1 | Copy 1 RAS |
| c1_cas_n | output | 1 | Copy 1 CAS |
| c1_we_n | output | 1 | Copy 1 WE |
| c1_bank | output | BW | Copy 1 bank |
| c1_addr | output | AW | Copy 1 address |
| cke_o | output | NCKE | Driven CKE levels |
| odt_o | output | NODT | Driven ODT levels |
| ck_run | output | 1 | 1: clock toggles, 0: clock held low |
| oe_ca | output | 1 | Enable for RAS/CAS/WE/bank/address on both copies |
| oe_cs | output | 1 | Enable for chip selects |
| oe_odt | output | 1 | Enable for ODT |
| oe_cke | output | 1 | Enable for CKE |
| oe_ck | output | 1 | Enable for clock |

## Verification
Every output is a single register stage, so the result of the inputs held before a rising edge is due just after that edge. The bench drives inputs at the falling edge, computes the expected values for the next edge from its own model state, and compares all outputs at the following falling edge. The CKE power-down float is the one result that depends on two edges. It is due one edge after CKE first reaches all zero, so the model keeps the previously driven CKE value and the directed sequence checks both the unchanged edge and the floating edge. Deselect hold, sleep and reset exits are checked on the cycle after the exit, where the held address must reappear.

// File: rtl/ca_pkg.sv
package ca_pkg;

  // Command codes formed as {ras_n, cas_n, we_n}
  typedef enum logic [2:0] {
    OP_MODE = 3'b000,
    OP_REF  = 3'b001,
    OP_PRE  = 3'b010,
    OP_ACT  = 3'b011,
    OP_WR   = 3'b100,
    OP_RD   = 3'b101,
    OP_RSV  = 3'b110,
    OP_NOP  = 3'b111
  } ca_op_e;

  typedef enum logic [1:0] {
    PM_RUN      = 2'd0,
    PM_CORE_RST = 2'd1,
    PM_SLEEP    = 2'd2
  } ca_pwr_e;

  typedef struct packed {
    logic ca;
    logic cs;
    logic odt;
    logic cke;
    logic ck;
  } ca_oe_t;

  // Column bit that selects auto-precharge / all-bank precharge
  localparam int AUTO_PRE_BIT = 10;

endpackage

// File: rtl/ca_cmd_decode.sv
module ca_cmd_decode
  import ca_pkg::*;
#(
  parameter int NCS = 2
) (
  input  logic           valid,
  input  logic [NCS-1:0] cs_n,
  input  logic           ras_n,
  input  logic           cas_n,
  input  logic           we_n,
  output logic           issue,
  output logic           is_mode,
  output logic           is_rwp
);

  ca_op_e op;

  always_comb begin
    op      = ca_op_e'({ras_n, cas_n, we_n});
    issue   = valid && !(&cs_n) && (op != OP_NOP);
    is_mode = (op == OP_MODE);
    is_rwp  = (op == OP_RD) || (op == OP_WR) || (op == OP_PRE);
  end

endmodule

// File: rtl/ca_inv_mask.sv
module ca_inv_mask #(
  parameter int AW     = 14,
  parameter int BW     = 3,
  parameter int AP_BIT = 10
) (
  input  logic          bal_off,
  input  logic          seq_a0,
  input  logic          is_mode,
  input  logic          is_rwp,
  output logic [AW-1:0] addr_mask,
  output logic [BW-1:0] bank_mask
);

  logic inv_all;

  assign inv_all   = !bal_off && !is_mode;
  assign bank_mask = {BW{inv_all}};

  for (genvar i = 0; i < AW; i++) begin : g_abit
    if (i == AP_BIT) begin : g_ap
      assign addr_mask[i] = inv_all && !is_rwp;
    end else if (i == 0) begin : g_a0
      assign addr_mask[i] = inv_all && !(is_rwp && seq_a0);
    end else begin : g_plain
      assign addr_mask[i] = inv_all;
    end
  end

endmodule

// File: rtl/ca_oe_ctrl.sv
module ca_oe_ctrl
  import ca_pkg::*;
#(
  parameter int NCKE = 2
) (
  input  ca_pwr_e         pwr,
  input  logic            flt_ca,
  input  logic            flt_cs,
  input  logic            flt_odt,
  input  logic            flt_cke,
  input  logic            flt_ck,
  input  logic [NCKE-1:0] cke_now,
  input  logic [NCKE-1:0] cke_nxt,
  output ca_oe_t          oe_nxt
);

  logic pd_float;

  always_comb begin
    pd_float = (cke_now == '0) && (cke_nxt == '0);
    unique case (pwr)
      PM_SLEEP: begin
        oe_nxt.ca  = 1'b1;
        oe_nxt.cs  = 1'b1;
        oe_nxt.odt = 1'b1;
        oe_nxt.cke = 1'b1;
        oe_nxt.ck  = 1'b1;
      end
      PM_CORE_RST: begin
        oe_nxt.ca  = 1'b0;
        oe_nxt.cs  = 1'b0;
        oe_nxt.odt = 1'b1;
        oe_nxt.cke = 1'b1;
        oe_nxt.ck  = 1'b1;
      end
      default: begin
        oe_nxt.ca  = !flt_ca && !pd_float;
        oe_nxt.cs  = !flt_cs && !pd_float;
        oe_nxt.odt = !flt_odt;
        oe_nxt.cke = !flt_cke;
        oe_nxt.ck  = !flt_ck;
      end
    endcase
  end

endmodule

// File: rtl/ca_balance_drv.sv
module ca_balance_drv
  import ca_pkg::*;
#(
  parameter int NCS  = 2,
  parameter int NCKE = 2,
  parameter int NODT = 2,
  parameter int AW   = 14,
  parameter int BW   = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            core_rst,
  input  logic            sleep_s3,
  input  logic            cfg_bal_off,
  input  logic            cfg_seq_a0,
  input  logic            flt_ca,
  input  logic            flt_cs,
  input  logic            flt_odt,
  input  logic            flt_cke,
  input  logic            flt_ck,
  input  logic            cmd_valid,
  input  logic [NCS-1:0]  cmd_cs_n,
  input  logic            cmd_ras_n,
  input  logic            cmd_cas_n,
  input  logic            cmd_we_n,
  input  logic [BW-1:0]   cmd_bank,
  input  logic [AW-1:0]   cmd_addr,
  input  logic [NCKE-1:0] cke_req,
  input  logic [NODT-1:0] odt_req,
  output logic [NCS-1:0]  c0_cs_n,
  output logic            c0_ras_n,
  output logic            c0_cas_n,
  output logic            c0_we_n,
  output logic [BW-1:0]   c0_bank,
  output logic [AW-1:0]   c0_addr,
  output logic [NCS-1:0]  c1_cs_n,
  output logic            c1_ras_n,
  output logic            c1_cas_n,
  output logic            c1_we_n,
  output logic [BW-1:0]   c1_bank,
  output logic [AW-1:0]   c1_addr,
  output logic [NCKE-1:0] cke_o,
  output logic [NODT-1:0] odt_o,
  output logic            ck_run,
  output logic            oe_ca,
  output logic            oe_cs,
  output logic            oe_odt,
  output logic            oe_cke,
  output logic            oe_ck
);

  localparam int CW = NCS + 3;  // chip selects plus RAS/CAS/WE

  ca_pwr_e         pwr;
  logic            issue, is_mode, is_rwp, take;
  logic [AW-1:0]   addr_mask;
  logic [BW-1:0]   bank_mask;
  logic [CW-1:0]   ctl_n, ctl0_q, ctl1_q;
  logic [AW-1:0]   addr0_q, addr1_q;
  logic [BW-1:0]   bank0_q, bank1_q;
  logic [NCKE-1:0] cke_n, cke_q;
  logic [NODT-1:0] odt_n, odt_q;
  logic            ck_n, ck_q, sleep_q;
  ca_oe_t          oe_n, oe_q;

  ca_cmd_decode #(.NCS(NCS)) u_dec (
    .valid   (cmd_valid),
    .cs_n    (cmd_cs_n),
    .ras_n   (cmd_ras_n),
    .cas_n   (cmd_cas_n),
    .we_n    (cmd_we_n),
    .issue   (issue),
    .is_mode (is_mode),
    .is_rwp  (is_rwp)
  );

  ca_inv_mask #(.AW(AW), .BW(BW), .AP_BIT(AUTO_PRE_BIT)) u_mask (
    .bal_off   (cfg_bal_off),
    .seq_a0    (cfg_seq_a0),
    .is_mode   (is_mode),
    .is_rwp    (is_rwp),
    .addr_mask (addr_mask),
    .bank_mask (bank_mask)
  );

  ca_oe_ctrl #(.NCKE(NCKE)) u_oe (
    .pwr     (pwr),
    .flt_ca  (flt_ca),
    .flt_cs  (flt_cs),
    .flt_odt (flt_odt),
    .flt_cke (flt_cke),
    .flt_ck  (flt_ck),
    .cke_now (cke_q),
    .cke_nxt (cke_n),
    .oe_nxt  (oe_n)
  );

  // Next-state logic
  always_comb begin
    if (sleep_s3)      pwr = PM_SLEEP;
    else if (core_rst) pwr = PM_CORE_RST;
    else               pwr = PM_RUN;

    take = (pwr == PM_RUN) && issue;

    if (pwr == PM_SLEEP)
      ctl_n = '0;
    else if (take)
      ctl_n = {cmd_cs_n, cmd_ras_n, cmd_cas_n, cmd_we_n};
    else
      ctl_n = {{NCS{1'b1}}, 3'b000};

    cke_n = (pwr == PM_RUN) ? cke_req : '0;
    odt_n = (pwr == PM_RUN) ? odt_req : '0;
    ck_n  = (pwr != PM_SLEEP);
  end

  // Command registers, one set per copy
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl0_q <= {{NCS{1'b1}}, 3'b000};
      ctl1_q <= {{NCS{1'b1}}, 3'b000};
    end else begin
      ctl0_q <= ctl_n;
      ctl1_q <= ctl_n;
    end
  end

  // Address/bank hold registers, loaded only on a taken command
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr0_q <= '0;
      bank0_q <= '0;
      addr1_q <= '1;
      bank1_q <= '1;
    end else if (take) begin
      addr0_q <= cmd_addr;
      bank0_q <= cmd_bank;
      addr1_q <= cmd_addr ^ addr_mask;
      bank1_q <= cmd_bank ^ bank_mask;
    end
  end

  // Power-control registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cke_q   <= '0;
      odt_q   <= '0;
      ck_q    <= 1'b0;
      sleep_q <= 1'b0;
      oe_q    <= '0;
    end else begin
      cke_q   <= cke_n;
      odt_q   <= odt_n;
      ck_q    <= ck_n;
      sleep_q <= (pwr == PM_SLEEP);
      oe_q    <= oe_n;
    end
  end

  // Output mapping; sleep drives zero without losing the held address
  assign {c0_cs_n, c0_ras_n, c0_cas_n, c0_we_n} = ctl0_q;
  assign {c1_cs_n, c1_ras_n, c1_cas_n, c1_we_n} = ctl1_q;
  assign c0_addr = sleep_q ? '0 : addr0_q;
  assign c0_bank = sleep_q ? '0 : bank0_q;
  assign c1_addr = sleep_q ? '0 : addr1_q;
  assign c1_bank = sleep_q ? '0 : bank1_q;
  assign cke_o   = cke_q;
  assign odt_o   = odt_q;
  assign ck_run  = ck_q;
  assign oe_ca   = oe_q.ca;
  assign oe_cs   = oe_q.cs;
  assign oe_odt  = oe_q.odt;
  assign oe_cke  = oe_q.cke;
  assign oe_ck   = oe_q.ck;

endmodule

// File: rtl/ca_balance_chk.sv
module ca_balance_chk #(
  parameter int NCS    = 2,
  parameter int NCKE   = 2,
  parameter int AW     = 14,
  parameter int BW     = 3,
  parameter int AP_BIT = 10
) (
  input logic            clk,
  input logic            rst_n,
  input logic            core_rst,
  input logic            sleep_s3,
  input logic            cfg_bal_off,
  input logic            cfg_seq_a0,
  input logic            flt_ca,
  input logic            flt_cs,
  input logic            cmd_valid,
  input logic [NCS-1:0]  cmd_cs_n,
  input logic            cmd_ras_n,
  input logic            cmd_cas_n,
  input logic            cmd_we_n,
  input logic [NCKE-1:0] cke_req,
  input logic [NCS-1:0]  c0_cs_n,
  input logic            c0_ras_n,
  input logic            c0_cas_n,
  input logic            c0_we_n,
  input logic [BW-1:0]   c0_bank,
  input logic [AW-1:0]   c0_addr,
  input logic [NCS-1:0]  c1_cs_n,
  input logic            c1_ras_n,
  input logic            c1_cas_n,
  input logic            c1_we_n,
  input logic [BW-1:0]   c1_bank,
  input logic [AW-1:0]   c1_addr,
  input logic [NCKE-1:0] cke_o,
  input logic            ck_run,
  input logic            oe_ca,
  input logic            oe_cs,
  input logic            oe_odt,
  input logic            oe_cke,
  input logic            oe_ck
);

  logic       run, iss;
  logic [2:0] op;
  assign op  = {cmd_ras_n, cmd_cas_n, cmd_we_n};
  assign run = !sleep_s3 && !core_rst;
  assign iss = run && cmd_valid && !(&cmd_cs_n) && (op != 3'b111);

  AST_CTRL_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    {c0_cs_n, c0_ras_n, c0_cas_n, c0_we_n} == {c1_cs_n, c1_ras_n, c1_cas_n, c1_we_n}); // R2

  AST_XCOPY_INV: assert property (@(posedge clk) disable iff (!rst_n)
    (iss && !cfg_bal_off && op == 3'b011) |=> (c1_addr == ~c0_addr) && (c1_bank == ~c0_bank)); // R3

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!sleep_s3 && ck_run && !iss) |=> $stable(c0_addr) && $stable(c1_addr) && $stable(c0_bank)); // R4

  AST_IDLE_DESEL: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !iss) |=> (&c0_cs_n) && !c0_ras_n && !c0_cas_n && !c0_we_n); // R4

  AST_AP_SAME: assert property (@(posedge clk) disable iff (!rst_n)
    (iss && (op == 3'b101 || op == 3'b100 || op == 3'b010)) |=> c1_addr[AP_BIT] == c0_addr[AP_BIT]); // R5

  AST_MODE_SAME: assert property (@(posedge clk) disable iff (!rst_n)
    (iss && op == 3'b000) |=> (c1_addr == c0_addr) && (c1_bank == c0_bank)); // R6

  AST_SEQ_A0: assert property (@(posedge clk) disable iff (!rst_n)
    (iss && cfg_seq_a0 && (op == 3'b101 || op == 3'b100)) |=> c1_addr[0] == c0_addr[0]); // R7

  AST_BAL_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (iss && cfg_bal_off) |=> (c1_addr == c0_addr) && (c1_bank == c0_bank)); // R8

  AST_S3_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_s3 |=> (cke_o == '0) && !ck_run && (c0_addr == '0) && (c1_cs_n == '0)
                 && oe_ca && oe_cs && oe_odt && oe_cke && oe_ck); // R9

  AST_CORE_RST: assert property (@(posedge clk) disable iff (!rst_n)
    (core_rst && !sleep_s3) |=> (cke_o == '0) && ck_run && !oe_ca && !oe_cs && oe_cke); // R10

  AST_FLT_CA: assert property (@(posedge clk) disable iff (!rst_n)
    (run && flt_ca && !flt_cs && (cke_req != '0)) |=> !oe_ca && oe_cs); // R11

  AST_PD_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !flt_ca && !flt_cs && (cke_req != '0)) |=> oe_ca && oe_cs); // R12

  AST_PRIO: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep_s3 && core_rst) |=> !ck_run && oe_ca); // R13

endmodule

bind ca_balance_drv ca_balance_chk #(
  .NCS(NCS), .NCKE(NCKE), .AW(AW), .BW(BW), .AP_BIT(ca_pkg::AUTO_PRE_BIT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .core_rst(core_rst), .sleep_s3(sleep_s3),
  .cfg_bal_off(cfg_bal_off), .cfg_seq_a0(cfg_seq_a0),
  .flt_ca(flt_ca), .flt_cs(flt_cs),
  .cmd_valid(cmd_valid), .cmd_cs_n(cmd_cs_n), .cmd_ras_n(cmd_ras_n),
  .cmd_cas_n(cmd_cas_n), .cmd_we_n(cmd_we_n), .cke_req(cke_req),
  .c0_cs_n(c0_cs_n), .c0_ras_n(c0_ras_n), .c0_cas_n(c0_cas_n), .c0_we_n(c0_we_n),
  .c0_bank(c0_bank), .c0_addr(c0_addr),
  .c1_cs_n(c1_cs_n), .c1_ras_n(c1_ras_n), .c1_cas_n(c1_cas_n), .c1_we_n(c1_we_n),
  .c1_bank(c1_bank), .c1_addr(c1_addr),
  .cke_o(cke_o), .ck_run(ck_run),
  .oe_ca(oe_ca), .oe_cs(oe_cs), .oe_odt(oe_odt), .oe_cke(oe_cke), .oe_ck(oe_ck)
);

// File: tb/ca_balance_drv_bench.sv
module ca_balance_drv_bench;

  localparam int NCS  = 2;
  localparam int NCKE = 2;
  localparam int NODT = 2;
  localparam int AW   = 14;
  localparam int BW   = 3;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic            rst_n, core_rst, sleep_s3, cfg_bal_off, cfg_seq_a0;
  logic            flt_ca, flt_cs, flt_odt, flt_cke, flt_ck;
  logic            cmd_valid, cmd_ras_n, cmd_cas_n, cmd_we_n;
  logic [NCS-1:0]  cmd_cs_n;
  logic [BW-1:0]   cmd_bank;
  logic [AW-1:0]   cmd_addr;
  logic [NCKE-1:0] cke_req;
  logic [NODT-1:0] odt_req;
  logic [NCS-1:0]  c0_cs_n, c1_cs_n;
  logic            c0_ras_n, c0_cas_n, c0_we_n, c1_ras_n, c1_cas_n, c1_we_n;
  logic [BW-1:0]   c0_bank, c1_bank;
  logic [AW-1:0]   c0_addr, c1_addr;
  logic [NCKE-1:0] cke_o;
  logic [NODT-1:0] odt_o;
  logic            ck_run, oe_ca, oe_cs, oe_odt, oe_cke, oe_ck;

  ca_balance_drv #(.NCS(NCS), .NCKE(NCKE), .NODT(NODT), .AW(AW), .BW(BW)) u_ca_balance_drv (
    .clk(clk), .rst_n(rst_n), .core_rst(core_rst), .sleep_s3(sleep_s3),
    .cfg_bal_off(cfg_bal_off), .cfg_seq_a0(cfg_seq_a0),
    .flt_ca(flt_ca), .flt_cs(flt_cs), .flt_odt(flt_odt), .flt_cke(flt_cke), .flt_ck(flt_ck),
    .cmd_valid(cmd_valid), .cmd_cs_n(cmd_cs_n), .cmd_ras_n(cmd_ras_n),
    .cmd_cas_n(cmd_cas_n), .cmd_we_n(cmd_we_n), .cmd_bank(cmd_bank), .cmd_addr(cmd_addr),
    .cke_req(cke_req), .odt_req(odt_req),
    .c0_cs_n(c0_cs_n), .c0_ras_n(c0_ras_n), .c0_cas_n(c0_cas_n), .c0_we_n(c0_we_n),
    .c0_bank(c0_bank), .c0_addr(c0_addr),
    .c1_cs_n(c1_cs_n), .c1_ras_n(c1_ras_n), .c1_cas_n(c1_cas_n), .c1_we_n(c1_we_n),
    .c1_bank(c1_bank), .c1_addr(c1_addr),
    .cke_o(cke_o), .odt_o(odt_o), .ck_run(ck_run),
    .oe_ca(oe_ca), .oe_cs(oe_cs), .oe_odt(oe_odt), .oe_cke(oe_cke), .oe_ck(oe_ck)
  );

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  // Model state
  logic [AW-1:0]   m_a0, m_a1;
  logic [BW-1:0]   m_b0, m_b1;
  logic [NCKE-1:0] m_cke;
  // Expected outputs
  logic [NCS+2:0]  e_ctl;
  logic [AW-1:0]   e_a0, e_a1;
  logic [BW-1:0]   e_b0, e_b1;
  logic [NCKE-1:0] e_cke;
  logic [NODT-1:0] e_odt;
  logic            e_ck;
  logic [4:0]      e_oe;

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic model_step();
    logic          run, iss, pd;
    logic [2:0]    op;
    logic [AW-1:0] am;
    logic [BW-1:0] bm;
    op  = {cmd_ras_n, cmd_cas_n, cmd_we_n};
    run = !sleep_s3 && !core_rst;
    iss = run && cmd_valid && !(&cmd_cs_n) && (op != 3'b111);
    am  = (cfg_bal_off || op == 3'b000) ? '0 : '1;
    bm  = (cfg_bal_off || op == 3'b000) ? '0 : '1;
    if (op == 3'b101 || op == 3'b100 || op == 3'b010) begin
      am[10] = 1'b0;
      if (cfg_seq_a0) am[0] = 1'b0;
    end
    if (iss) begin
      m_a0 = cmd_addr; m_a1 = cmd_addr ^ am;
      m_b0 = cmd_bank; m_b1 = cmd_bank ^ bm;
    end
    if (sleep_s3)  e_ctl = '0;
    else if (iss)  e_ctl = {cmd_cs_n, op};
    else           e_ctl = {{NCS{1'b1}}, 3'b000};
    e_a0  = sleep_s3 ? '0 : m_a0;
    e_a1  = sleep_s3 ? '0 : m_a1;
    e_b0  = sleep_s3 ? '0 : m_b0;
    e_b1  = sleep_s3 ? '0 : m_b1;
    e_cke = run ? cke_req : '0;
    e_odt = run ? odt_req : '0;
    e_ck  = !sleep_s3;
    pd    = (m_cke == '0) && (e_cke == '0);
    if (sleep_s3)      e_oe = 5'b11111;
    else if (core_rst) e_oe = 5'b00111;
    else e_oe = {!flt_ca && !pd, !flt_cs && !pd, !flt_odt, !flt_cke, !flt_ck};
    m_cke = e_cke;
  endtask

  task automatic cyc(string tag);
    model_step();
    @(posedge clk);
    @(negedge clk);
    chk(tag, "copy0 ctl", 32'({c0_cs_n, c0_ras_n, c0_cas_n, c0_we_n}), 32'(e_ctl));
    chk(tag, "copy1 ctl", 32'({c1_cs_n, c1_ras_n, c1_cas_n, c1_we_n}), 32'(e_ctl));
    chk(tag, "c0_addr", 32'(c0_addr), 32'(e_a0));
    chk(tag, "c1_addr", 32'(c1_addr), 32'(e_a1));
    chk(tag, "c0_bank", 32'(c0_bank), 32'(e_b0));
    chk(tag, "c1_bank", 32'(c1_bank), 32'(e_b1));
    chk(tag, "cke/odt/ck", 32'({cke_o, odt_o, ck_run}), 32'({e_cke, e_odt, e_ck}));
    chk(tag, "oe", 32'({oe_ca, oe_cs, oe_odt, oe_cke, oe_ck}), 32'(e_oe));
  endtask

  task automatic set_cmd(logic [2:0] op, logic [NCS-1:0] cs, logic [BW-1:0] b, logic [AW-1:0] a);
    cmd_valid = 1'b1;
    {cmd_ras_n, cmd_cas_n, cmd_we_n} = op;
    cmd_cs_n = cs; cmd_bank = b; cmd_addr = a;
  endtask

  task automatic idle();
    cmd_valid = 1'b0;
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4457));
    rst_n = 1'b0; core_rst = 0; sleep_s3 = 0; cfg_bal_off = 0; cfg_seq_a0 = 0;
    flt_ca = 0; flt_cs = 0; flt_odt = 0; flt_cke = 0; flt_ck = 0;
    cmd_valid = 0; cmd_cs_n = '1; cmd_ras_n = 1; cmd_cas_n = 1; cmd_we_n = 1;
    cmd_bank = '0; cmd_addr = '0; cke_req = '0; odt_req = '0;
    m_a0 = '0; m_a1 = '1; m_b0 = '0; m_b1 = '1; m_cke = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", "ctl", 32'({c0_cs_n, c0_ras_n, c0_cas_n, c0_we_n, c1_cs_n, c1_ras_n, c1_cas_n, c1_we_n}),
        32'({2'b11, 3'b000, 2'b11, 3'b000}));
    chk("R1", "addr/bank", 32'({c0_addr, c1_addr, c0_bank, c1_bank}), 32'({14'h0, 14'h3fff, 3'h0, 3'h7}));
    chk("R1", "pwr/oe", 32'({cke_o, odt_o, ck_run, oe_ca, oe_cs, oe_odt, oe_cke, oe_ck}), 32'(0));
    rst_n = 1'b1;

    // R12 after reset CKE low -> ca/cs float; wake same edge
    cyc("R12");
    cke_req = 2'b11; odt_req = 2'b01;
    cyc("R12");
    // R3 plain inversion
    set_cmd(3'b011, 2'b10, 3'h5, 14'h1a5c); cyc("R3");
    set_cmd(3'b001, 2'b00, 3'h2, 14'h0401); cyc("R3");
    // R4 idle hold and balanced deselect
    idle(); cyc("R4"); cyc("R4");
    // R5 A10 same on read/write/precharge
    set_cmd(3'b101, 2'b01, 3'h3, 14'h0455); cyc("R5");
    set_cmd(3'b100, 2'b10, 3'h1, 14'h3bff); cyc("R5");
    set_cmd(3'b010, 2'b10, 3'h6, 14'h0400); cyc("R5");
    // R6 mode register set uninverted
    set_cmd(3'b000, 2'b00, 3'h4, 14'h0a31); cyc("R6");
    // R7 sequential A0
    cfg_seq_a0 = 1;
    set_cmd(3'b101, 2'b10, 3'h0, 14'h0123); cyc("R7");
    set_cmd(3'b011, 2'b10, 3'h0, 14'h0123); cyc("R7");
    cfg_seq_a0 = 0;
    // R8 balance off
    cfg_bal_off = 1;
    set_cmd(3'b011, 2'b01, 3'h7, 14'h2ae1); cyc("R8");
    set_cmd(3'b101, 2'b01, 3'h7, 14'h1111); cyc("R8");
    cfg_bal_off = 0;
    // R2 NOP with cs low, cmd_valid low, cs all high -> not issued
    set_cmd(3'b111, 2'b00, 3'h1, 14'h0fff); cyc("R2");
    set_cmd(3'b011, 2'b11, 3'h1, 14'h0fff); cyc("R2");
    set_cmd(3'b011, 2'b00, 3'h1, 14'h0fff); cmd_valid = 0; cyc("R2");
    set_cmd(3'b110, 2'b10, 3'h2, 14'h00f0); cyc("R2");
    idle();
    // R11 individual float bits
    flt_ca = 1; cyc("R11"); flt_ca = 0;
    flt_cs = 1; cyc("R11"); flt_cs = 0;
    flt_odt = 1; cyc("R11"); flt_odt = 0;
    flt_cke = 1; cyc("R11"); flt_cke = 0;
    flt_ck = 1; cyc("R11"); flt_ck = 0;
    // R12 CKE drop: first edge still driven, next edge floats, wake restores
    cke_req = 2'b10; cyc("R12");
    cke_req = 2'b00; cyc("R12"); cyc("R12"); cyc("R12");
    cke_req = 2'b01; cyc("R12");
    cke_req = 2'b11;
    // R10 core reset ignores commands
    core_rst = 1;
    set_cmd(3'b011, 2'b00, 3'h3, 14'h3333); cyc("R10"); cyc("R10");
    core_rst = 0; idle(); cyc("R10");
    // R9 sleep drives everything low, hold survives
    sleep_s3 = 1;
    set_cmd(3'b011, 2'b00, 3'h6, 14'h2222); cyc("R9"); cyc("R9");
    sleep_s3 = 0; idle(); cyc("R9");
    // R13 priority
    sleep_s3 = 1; core_rst = 1; flt_ca = 1; cyc("R13");
    sleep_s3 = 0; flt_ck = 1; cyc("R13");
    core_rst = 0; cyc("R13");
    flt_ca = 0; flt_ck = 0; cke_req = 2'b00; cyc("R13"); flt_cs = 1; cyc("R13");
    flt_cs = 0; cke_req = 2'b11;

    // Constrained random
    for (int i = 0; i < 3000; i++) begin
      sleep_s3    = ($urandom_range(99) < 3);
      core_rst    = ($urandom_range(99) < 5);
      cfg_bal_off = ($urandom_range(99) < 20);
      cfg_seq_a0  = ($urandom_range(99) < 30);
      flt_ca  = ($urandom_range(99) < 5);
      flt_cs  = ($urandom_range(99) < 5);
      flt_odt = ($urandom_range(99) < 5);
      flt_cke = ($urandom_range(99) < 5);
      flt_ck  = ($urandom_range(99) < 5);
      cke_req = ($urandom_range(99) < 85) ? 2'b11 : NCKE'($urandom);
      odt_req = NODT'($urandom);
      cmd_valid = ($urandom_range(99) < 70);
      {cmd_ras_n, cmd_cas_n, cmd_we_n} = 3'($urandom);
      cmd_cs_n = NCS'($urandom);
      cmd_bank = BW'($urandom);
      cmd_addr = AW'($urandom);
      cyc("RAND");
    end

    done = 1'b1;
    summary();
    $finish;
  end

endmodule